// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Link

This block is one stage of a priority chain for vectored interrupts. Each stage holds a local interrupt request. While that request is pending, the stage pulls a shared, active-low interrupt line low. The line is an open-drain line: the outputs of all stages are combined by a wired AND, so any single stage can hold it low. The line goes high again only when no stage is pulling.

The acknowledge is not shared. It runs through the stages in series. Each stage takes the acknowledge from the stage above it and decides whether to keep it or pass it on.
- A stage with no pending request forwards the acknowledge to the stage below in the same cycle.
- A stage with a pending request keeps the acknowledge. It blocks the downstream output and drives its own identification vector onto the shared data bus.

Because of this, the stage nearest the processor always wins, and priority comes only from position in the chain.

The keep-or-pass decision is frozen in the first cycle of an acknowledge. It cannot change while that acknowledge lasts. The serving stage clears its request on the first clock edge after the acknowledge drops.

Top module: `intr_chain_link`

## Requirements
- R1: After reset the link does not pull the interrupt line (`irqPullLow`=0) and does not drive the bus (`vecOe`=0, `vecOut`=0).
- R2: A rising edge on `reqIn` makes the request pending, so `irqPullLow` is 1 after the next clock edge. Holding `reqIn` high does not raise a new request after that request has been served.
- R3: When `ackIn` is 1 and no request is pending, `ackOut` equals 1 in the same cycle, and `vecOe` and `vecOut` stay 0.
- R4: When `ackIn` is 1 and a request is pending, the link does three things in the same cycle: `ackOut` is 0, `vecOe` is 1, and `vecOut` equals the instance's `VECTOR` parameter.
- R5: The keep-or-pass decision is taken in the first cycle of `ackIn` high and holds while `ackIn` stays high. A request that arrives during that acknowledge changes neither `ackOut` nor the bus. It stays pending for a later acknowledge.
- R6: After an acknowledge that the link kept, the request clears on the first clock edge at which `ackIn` is 0. From that edge on, `irqPullLow` is 0.
- R7: In a chain of links, acknowledges are served in chain order, nearest stage first. The wired-AND line stays low until the last requesting stage has been served.
- R8: `ackOut` and `vecOe` are never 1 while `ackIn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 1 | Local interrupt request; a rising edge raises a request |
| ackIn | input | 1 | Acknowledge from the upstream neighbour, active high |
| ackOut | output | 1 | Acknowledge passed to the downstream neighbour |
| irqPullLow | output | 1 | 1 = pull the shared open-drain interrupt line low |
| vecOe | output | 1 | Data-bus drive enable for the vector |
| vecOut | output | VEC_W | Vector value; zero when not driving |

## Verification
The hardest case is a request that arrives while an acknowledge is already held by a stage further down the chain. The correct result is that the upstream stage keeps forwarding that acknowledge, and its own request waits for the next acknowledge. To reach this state, the bench stretches one acknowledge over several cycles and raises the upstream request in the middle of it. It then checks the bus, the forwarded acknowledge and the shared line before and after the next acknowledge. A second hard case is several requests raised in the same cycle. Here the bench steps through one acknowledge at a time and checks that the shared line stays low until the last vector has been read.

// File: rtl/intr_link_pkg.sv
package intr_link_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic driveVec;   // this link holds the acknowledge
    logic retire;     // acknowledge just ended after this link served it
  } linkStrobe_t;
endpackage

// File: rtl/intr_link_ctrl.sv
module intr_link_ctrl
  import intr_link_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ackIn,
  input  logic        pendingReq,
  output logic        ackOut,
  output linkStrobe_t strobe
);
  logic ackSeen;
  logic heldClaim;
  logic claimNow;

  // Decision: live only in the first acknowledge cycle, frozen afterwards
  assign claimNow = ackIn & (ackSeen ? heldClaim : pendingReq);
  assign ackOut   = ackIn & ~claimNow;

  assign strobe.driveVec = claimNow;
  assign strobe.retire   = ~ackIn & ackSeen & heldClaim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackSeen   <= 1'b0;
      heldClaim <= 1'b0;
    end else begin
      ackSeen <= ackIn;
      if (ackIn && !ackSeen) begin
        heldClaim <= pendingReq;
      end else if (!ackIn) begin
        heldClaim <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/intr_link_dp.sv
module intr_link_dp
  import intr_link_pkg::*;
#(
  parameter int unsigned      VEC_W  = 8,
  parameter logic [VEC_W-1:0] VECTOR = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqIn,
  input  linkStrobe_t      strobe,
  output logic             pendingReq,
  output logic             vecOe,
  output logic [VEC_W-1:0] vecOut
);
  logic reqPrev;
  logic reqEdge;

  assign reqEdge = reqIn & ~reqPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev    <= 1'b0;
      pendingReq <= 1'b0;
    end else begin
      reqPrev    <= reqIn;
      // a fresh edge wins over retirement in the same cycle
      pendingReq <= (pendingReq & ~strobe.retire) | reqEdge;
    end
  end

  assign vecOe  = strobe.driveVec;
  assign vecOut = strobe.driveVec ? VECTOR : '0;
endmodule

// File: rtl/intr_chain_link.sv
module intr_chain_link
  import intr_link_pkg::*;
#(
  parameter int unsigned      VEC_W  = 8,
  parameter logic [VEC_W-1:0] VECTOR = 8'h40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqIn,
  input  logic             ackIn,
  output logic             ackOut,
  output logic             irqPullLow,
  output logic             vecOe,
  output logic [VEC_W-1:0] vecOut
);
  linkStrobe_t strobe;
  logic        pendingReq;

  intr_link_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ackIn      (ackIn),
    .pendingReq (pendingReq),
    .ackOut     (ackOut),
    .strobe     (strobe)
  );

  intr_link_dp #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .strobe     (strobe),
    .pendingReq (pendingReq),
    .vecOe      (vecOe),
    .vecOut     (vecOut)
  );

  assign irqPullLow = pendingReq;
endmodule

// File: rtl/intr_chain_link_chk.sv
module intr_chain_link_chk #(
  parameter int unsigned      VEC_W  = 8,
  parameter logic [VEC_W-1:0] VECTOR = 8'h40
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqIn,
  input logic             ackIn,
  input logic             ackOut,
  input logic             irqPullLow,
  input logic             vecOe,
  input logic [VEC_W-1:0] vecOut
);
  // R8
  ack_needs_upstream_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut || vecOe) |-> ackIn);

  // R4
  claim_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |-> (!ackOut && vecOut == VECTOR));

  // R3
  idle_passes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !irqPullLow) |-> (ackOut && !vecOe && vecOut == '0));

  // R5
  frozen_decision_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && $past(ackIn)) |-> (ackOut == $past(ackOut)));

  // R6
  release_after_serve_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqPullLow) |-> $past(vecOe, 2));

  // R2
  edge_raises_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn && !$past(reqIn)) |=> irqPullLow);
endmodule

bind intr_chain_link intr_chain_link_chk #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_chk (.*);

// File: tb/tb_intr_chain_link.sv
`timescale 1ns/1ps
module tb_intr_chain_link;
  localparam int W = 8;
  localparam logic [W-1:0] V0 = 8'hA1, V1 = 8'hB2, V2 = 8'hC3, V3 = 8'hD4;

  logic clk = 1'b0;
  logic rstN;
  logic [3:0] req;
  logic ackCpu;
  logic [3:0] ackO, pull, oe;
  logic [W-1:0] vo0, vo1, vo2, vo3;
  logic [W-1:0] dataBus;
  logic irqN;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intr_chain_link #(.VEC_W(W), .VECTOR(V0)) dut (
    .clk(clk), .rstN(rstN), .reqIn(req[0]), .ackIn(ackCpu), .ackOut(ackO[0]),
    .irqPullLow(pull[0]), .vecOe(oe[0]), .vecOut(vo0));
  intr_chain_link #(.VEC_W(W), .VECTOR(V1)) link1 (
    .clk(clk), .rstN(rstN), .reqIn(req[1]), .ackIn(ackO[0]), .ackOut(ackO[1]),
    .irqPullLow(pull[1]), .vecOe(oe[1]), .vecOut(vo1));
  intr_chain_link #(.VEC_W(W), .VECTOR(V2)) link2 (
    .clk(clk), .rstN(rstN), .reqIn(req[2]), .ackIn(ackO[1]), .ackOut(ackO[2]),
    .irqPullLow(pull[2]), .vecOe(oe[2]), .vecOut(vo2));
  intr_chain_link #(.VEC_W(W), .VECTOR(V3)) link3 (
    .clk(clk), .rstN(rstN), .reqIn(req[3]), .ackIn(ackO[2]), .ackOut(ackO[3]),
    .irqPullLow(pull[3]), .vecOe(oe[3]), .vecOut(vo3));

  // wired-AND open-drain line and OR-combined bus
  assign irqN    = ~|pull;
  assign dataBus = vo0 | vo1 | vo2 | vo3;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle acknowledge, check bus while held, then drop it
  task automatic ackCycle(input string tag, input logic [W-1:0] expVec);
    ackCpu = 1'b1;
    #1;
    chk({tag, " bus vector"}, {24'd0, dataBus}, {24'd0, expVec});
    chk({tag, " single driver"}, $countones(oe), 1);
    tick();
    ackCpu = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 irq line released", irqN, 1);
    chk("R1 no drive", oe, 0);
    chk("R1 bus zero", dataBus, 0);
    chk("R8 no ackOut without ackIn", ackO, 0);
  endtask

  task automatic t_passThrough();
    ackCpu = 1'b1;
    #1;
    chk("R3 ack reaches chain end", ackO, 4'hF);
    chk("R3 no drive", oe, 0);
    chk("R3 bus zero", dataBus, 0);
    tick();
    ackCpu = 1'b0;
    #1;
    chk("R8 ackOut follows ackIn low", ackO, 0);
    tick();
  endtask

  task automatic t_single();
    req[2] = 1'b1;
    tick();
    chk("R2 pending after edge", irqN, 0);
    ackCpu = 1'b1;
    #1;
    chk("R4 upstream passes", ackO[1:0], 2'b11);
    chk("R4 claimer blocks", ackO[3:2], 2'b00);
    chk("R4 vector driven", dataBus, V2);
    chk("R4 enable", oe, 4'b0100);
    tick();
    ackCpu = 1'b0;
    #1;
    chk("R6 still pulling before edge", irqN, 0);
    tick();
    chk("R6 released after edge", irqN, 1);
    tick();
    chk("R2 held level no new request", irqN, 1);
    req[2] = 1'b0;
    tick();
  endtask

  task automatic t_multi();
    req = 4'b1011;
    tick();
    chk("R7 line low", irqN, 0);
    ackCycle("R7 first", V0);
    chk("R7 low after first", irqN, 0);
    ackCycle("R7 second", V1);
    chk("R7 low after second", irqN, 0);
    ackCpu = 1'b1;
    #1;
    chk("R7 third vector", dataBus, V3);
    tick();
    ackCpu = 1'b0;
    #1;
    chk("R7 low until retire edge", irqN, 0);
    tick();
    chk("R7 released after last", irqN, 1);
    req = 4'b0000;
    tick();
  endtask

  task automatic t_freeze();
    req[2] = 1'b1;
    tick();
    ackCpu = 1'b1;
    #1;
    chk("R5 initial owner", dataBus, V2);
    tick();
    req[0] = 1'b1;   // late request upstream during held acknowledge
    tick();
    #1;
    chk("R5 bus unchanged", dataBus, V2);
    chk("R5 upstream still passes", ackO[0], 1);
    chk("R5 late request pending", pull[0], 1);
    ackCpu = 1'b0;
    tick();
    chk("R5 line still low for late request", irqN, 0);
    ackCycle("R5 late served next", V0);
    chk("R6 all released", irqN, 1);
    req = 4'b0000;
    tick();
  endtask

  initial begin
    rstN = 1'b0; req = '0; ackCpu = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_passThrough();
    t_single();
    t_multi();
    t_freeze();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule